// File: doc/BRIEF.md
# Split Page-Size Translation Lookaside Buffer

This block holds recently used virtual-to-physical translations in two separate set-associative arrays, one for 4 KB pages and one for 4 MB pages. Every lookup probes both arrays at once and returns, in the same cycle, a hit flag, the full physical address and a flag that tells which page size produced the hit. When a translation is missing, the block raises a miss pulse so that a page-table walker can fetch the entry. The walker then writes the entry back through a fill port that carries the page size.

Software-visible maintenance has two forms. A single-address invalidate removes any matching entry from either array. A full flush walks the arrays one set per cycle while a busy output is held high. The block emits one-cycle event outputs for fills, replacements and misses, and it reports how many entries were invalidated in each cycle, so that a flush counts every entry it clears. Instruction and data translation use two instances of this module with the same parameters.

Top module: `tlb_split`

## Requirements
- R1: After reset every entry is invalid, busy is low, every lookup misses, and no event output is active.
- R2: After a 4 KB fill of virtual page `fill_va[31:12]`, a lookup in that page hits with `lk_large`=0 and `lk_pa` = {fill physical page `fill_pa[31:12]`, `lk_va[11:0]`}, in the same cycle as the lookup.
- R3: After a 4 MB fill, any lookup whose `lk_va[31:22]` matches hits with `lk_large`=1 and `lk_pa` = {`fill_pa[31:22]`, `lk_va[21:0]`}.
- R4: When both arrays hold a translation for the looked-up address, the 4 MB entry supplies the result and `lk_large` is 1.
- R5: A valid lookup that finds no translation in either array raises `lk_miss` for that cycle only. `lk_miss` and `lk_hit` are never high together, and `lk_miss` needs `lk_valid`.
- R6: A fill into a set with a free way uses the lowest-numbered invalid way and does not assert `ev_replace`. A fill into a full set evicts the way chosen by that set's round-robin pointer, which starts at way 0 and advances on each eviction, and it asserts `ev_replace` together with `ev_fill`.
- R7: A fill whose page already has an entry in the target array overwrites that entry's physical page. It does not assert `ev_replace` and does not evict any other way.
- R8: An invalidate clears every entry in either array that translates `inv_va`. `ev_inval_cnt` equals the number cleared (0, 1 or 2) in that cycle, and is 0 in cycles with no invalidate and no flush.
- R9: A flush request raises `busy` at the next edge and keeps it high for exactly max(S_SETS, L_SETS) cycles, one set per cycle. The sum of `ev_inval_cnt` over those cycles equals the number of valid entries, and afterwards every lookup misses.
- R10: While `busy` is high, lookups report neither hit nor miss, and fill and invalidate requests are discarded.
- R11: The 4 KB set is `va[15:12]` and the 4 MB set is `va[22]`. Sixteen 4 KB pages that differ only in bits 15:12 all stay resident together, and two 4 MB pages that differ in bit 22 both stay resident.
- R12: When requests arrive in the same cycle, flush takes priority over invalidate, and invalidate takes priority over fill. The losing request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a translation |
| lk_pa | output | PA_W | Translated physical address |
| lk_large | output | 1 | Hit came from the 4 MB array |
| lk_miss | output | 1 | Miss event pulse |
| fill_valid | input | 1 | Walker fill request |
| fill_va | input | VA_W | Fill virtual address |
| fill_pa | input | PA_W | Fill physical address |
| fill_large | input | 1 | Fill targets the 4 MB array |
| inv_valid | input | 1 | Single-address invalidate request |
| inv_va | input | VA_W | Address to invalidate |
| flush_start | input | 1 | Start a full flush |
| busy | output | 1 | Flush walk in progress |
| ev_fill | output | 1 | Fill event pulse |
| ev_replace | output | 1 | Fill evicted a valid entry |
| ev_inval_cnt | output | CW | Entries invalidated this cycle |

## Verification
The bench targets the overlap case, where a 4 KB and a 4 MB entry both cover one address. A design that gives the small array priority returns the wrong frame and clears `lk_large`. It fills one set beyond its associativity twice in a row. A victim pointer that is missing or does not advance would evict the wrong page or skip `ev_replace`, and a first-free search that runs in the wrong direction would report a replacement too early. The bench also refills a page that is already resident, where a design that allocates a second way corrupts the set. It counts invalidate events across a flush, where a single pulse per flush or an off-by-one walk length would change the total. Finally it sends requests during the walk and requests that collide in one cycle, which expose a busy gate that leaks or a priority order that is reversed.

// File: rtl/tlb_split.sv
module tlb_split #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int S_WAYS = 4,
  parameter int S_SETS = 16,
  parameter int L_WAYS = 4,
  parameter int L_SETS = 2,
  localparam int CW    = $clog2(S_WAYS + L_WAYS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa,
  output logic            lk_large,
  output logic            lk_miss,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_va,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            fill_large,
  input  logic            inv_valid,
  input  logic [VA_W-1:0] inv_va,
  input  logic            flush_start,
  output logic            busy,
  output logic            ev_fill,
  output logic            ev_replace,
  output logic [CW-1:0]   ev_inval_cnt
);
  localparam int S_OFF = 12;
  localparam int L_OFF = 22;
  localparam int SIW   = $clog2(S_SETS);
  localparam int LIW   = $clog2(L_SETS);
  localparam int STW   = VA_W - S_OFF - SIW;
  localparam int LTW   = VA_W - L_OFF - LIW;
  localparam int SPW   = PA_W - S_OFF;
  localparam int LPW   = PA_W - L_OFF;
  localparam int SWW   = $clog2(S_WAYS);
  localparam int LWW   = $clog2(L_WAYS);
  localparam int WALK  = (S_SETS > L_SETS) ? S_SETS : L_SETS;
  localparam int FW    = $clog2(WALK);

  logic [S_WAYS-1:0] s_vld [S_SETS];
  logic [STW-1:0]    s_tag [S_SETS][S_WAYS];
  logic [SPW-1:0]    s_ppn [S_SETS][S_WAYS];
  logic [SWW-1:0]    s_rr  [S_SETS];
  logic [L_WAYS-1:0] l_vld [L_SETS];
  logic [LTW-1:0]    l_tag [L_SETS][L_WAYS];
  logic [LPW-1:0]    l_ppn [L_SETS][L_WAYS];
  logic [LWW-1:0]    l_rr  [L_SETS];
  logic [FW-1:0]     widx;

  // request decode
  logic do_inv, do_fill;
  assign do_inv  = inv_valid & ~busy & ~flush_start;
  assign do_fill = fill_valid & ~busy & ~flush_start & ~inv_valid;

  // lookup
  logic [SIW-1:0] ls_set;
  logic [LIW-1:0] ll_set;
  logic           ls_hit, ll_hit;
  logic [SPW-1:0] ls_ppn;
  logic [LPW-1:0] ll_ppn;
  assign ls_set = lk_va[S_OFF +: SIW];
  assign ll_set = lk_va[L_OFF +: LIW];

  always_comb begin
    ls_hit = 1'b0;
    ls_ppn = '0;
    for (int w = 0; w < S_WAYS; w++)
      if (s_vld[ls_set][w] && s_tag[ls_set][w] == lk_va[VA_W-1 -: STW]) begin
        ls_hit = 1'b1;
        ls_ppn = s_ppn[ls_set][w];
      end
    ll_hit = 1'b0;
    ll_ppn = '0;
    for (int w = 0; w < L_WAYS; w++)
      if (l_vld[ll_set][w] && l_tag[ll_set][w] == lk_va[VA_W-1 -: LTW]) begin
        ll_hit = 1'b1;
        ll_ppn = l_ppn[ll_set][w];
      end
  end

  assign lk_hit   = lk_valid & ~busy & (ls_hit | ll_hit);
  assign lk_miss  = lk_valid & ~busy & ~(ls_hit | ll_hit);
  assign lk_large = lk_hit & ll_hit;
  assign lk_pa    = ll_hit ? {ll_ppn, lk_va[L_OFF-1:0]} : {ls_ppn, lk_va[S_OFF-1:0]};

  // fill way selection
  logic [SIW-1:0] fs_set;
  logic [LIW-1:0] fl_set;
  logic           fs_hit, fs_free, fl_hit, fl_free;
  logic [SWW-1:0] fs_hw, fs_fw, fs_way;
  logic [LWW-1:0] fl_hw, fl_fw, fl_way;
  assign fs_set = fill_va[S_OFF +: SIW];
  assign fl_set = fill_va[L_OFF +: LIW];

  always_comb begin
    fs_hit = 1'b0; fs_hw = '0; fs_free = 1'b0; fs_fw = '0;
    for (int w = S_WAYS - 1; w >= 0; w--) begin
      if (!s_vld[fs_set][w]) begin
        fs_free = 1'b1;
        fs_fw   = SWW'(w);
      end
      if (s_vld[fs_set][w] && s_tag[fs_set][w] == fill_va[VA_W-1 -: STW]) begin
        fs_hit = 1'b1;
        fs_hw  = SWW'(w);
      end
    end
    fl_hit = 1'b0; fl_hw = '0; fl_free = 1'b0; fl_fw = '0;
    for (int w = L_WAYS - 1; w >= 0; w--) begin
      if (!l_vld[fl_set][w]) begin
        fl_free = 1'b1;
        fl_fw   = LWW'(w);
      end
      if (l_vld[fl_set][w] && l_tag[fl_set][w] == fill_va[VA_W-1 -: LTW]) begin
        fl_hit = 1'b1;
        fl_hw  = LWW'(w);
      end
    end
  end

  assign fs_way = fs_hit ? fs_hw : fs_free ? fs_fw : s_rr[fs_set];
  assign fl_way = fl_hit ? fl_hw : fl_free ? fl_fw : l_rr[fl_set];

  logic fs_repl, fl_repl;
  assign fs_repl = ~fs_hit & ~fs_free;
  assign fl_repl = ~fl_hit & ~fl_free;

  // invalidate match
  logic [SIW-1:0]    is_set;
  logic [LIW-1:0]    il_set;
  logic [S_WAYS-1:0] is_mask;
  logic [L_WAYS-1:0] il_mask;
  assign is_set = inv_va[S_OFF +: SIW];
  assign il_set = inv_va[L_OFF +: LIW];

  always_comb begin
    for (int w = 0; w < S_WAYS; w++)
      is_mask[w] = s_vld[is_set][w] && s_tag[is_set][w] == inv_va[VA_W-1 -: STW];
    for (int w = 0; w < L_WAYS; w++)
      il_mask[w] = l_vld[il_set][w] && l_tag[il_set][w] == inv_va[VA_W-1 -: LTW];
  end

  // flush walk
  logic [SIW-1:0] ws_set;
  logic [LIW-1:0] wl_set;
  logic           ws_in, wl_in;
  int             walk_n, inv_n;
  assign ws_set = widx[SIW-1:0];
  assign wl_set = widx[LIW-1:0];
  assign ws_in  = 32'(widx) < S_SETS;
  assign wl_in  = 32'(widx) < L_SETS;

  always_comb begin
    walk_n = 0;
    if (ws_in) walk_n += $countones(s_vld[ws_set]);
    if (wl_in) walk_n += $countones(l_vld[wl_set]);
    inv_n = $countones(is_mask) + $countones(il_mask);
  end

  assign ev_inval_cnt = busy ? CW'(walk_n) : do_inv ? CW'(inv_n) : '0;
  assign ev_fill      = do_fill;
  assign ev_replace   = do_fill & (fill_large ? fl_repl : fs_repl);

  // state with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < S_SETS; s++) begin
        s_vld[s] <= '0;
        s_rr[s]  <= '0;
      end
      for (int s = 0; s < L_SETS; s++) begin
        l_vld[s] <= '0;
        l_rr[s]  <= '0;
      end
      busy <= 1'b0;
      widx <= '0;
    end else if (busy) begin
      if (ws_in) begin
        s_vld[ws_set] <= '0;
        s_rr[ws_set]  <= '0;
      end
      if (wl_in) begin
        l_vld[wl_set] <= '0;
        l_rr[wl_set]  <= '0;
      end
      if (widx == FW'(WALK - 1)) busy <= 1'b0;
      widx <= widx + 1'b1;
    end else if (flush_start) begin
      busy <= 1'b1;
      widx <= '0;
    end else if (inv_valid) begin
      s_vld[is_set] <= s_vld[is_set] & ~is_mask;
      l_vld[il_set] <= l_vld[il_set] & ~il_mask;
    end else if (fill_valid) begin
      if (fill_large) begin
        l_vld[fl_set][fl_way] <= 1'b1;
        if (fl_repl) l_rr[fl_set] <= l_rr[fl_set] + 1'b1;
      end else begin
        s_vld[fs_set][fs_way] <= 1'b1;
        if (fs_repl) s_rr[fs_set] <= s_rr[fs_set] + 1'b1;
      end
    end
  end

  // payload, no reset
  always_ff @(posedge clk) begin
    if (do_fill) begin
      if (fill_large) begin
        l_tag[fl_set][fl_way] <= fill_va[VA_W-1 -: LTW];
        l_ppn[fl_set][fl_way] <= fill_pa[PA_W-1 -: LPW];
      end else begin
        s_tag[fs_set][fs_way] <= fill_va[VA_W-1 -: STW];
        s_ppn[fs_set][fs_way] <= fill_pa[PA_W-1 -: SPW];
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{fill_va[S_OFF-1:0], inv_va[S_OFF-1:0], fill_pa[S_OFF-1:0]};
endmodule

// File: rtl/tlb_split_chk.sv
module tlb_split_chk #(
  parameter int S_WAYS = 4,
  parameter int S_SETS = 16,
  parameter int L_WAYS = 4,
  parameter int L_SETS = 2,
  localparam int CW    = $clog2(S_WAYS + L_WAYS + 1),
  localparam int WALK  = (S_SETS > L_SETS) ? S_SETS : L_SETS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_hit,
  input logic          lk_miss,
  input logic          lk_large,
  input logic          fill_valid,
  input logic          inv_valid,
  input logic          flush_start,
  input logic          busy,
  input logic          ev_fill,
  input logic          ev_replace,
  input logic [CW-1:0] ev_inval_cnt
);
  int run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else        run <= busy ? run + 1 : 0;

  p_hit_miss_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) lk_hit |-> !lk_miss);
  p_miss_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n) lk_miss |-> lk_valid);
  p_large_is_hit_r4: assert property (@(posedge clk) disable iff (!rst_n) lk_large |-> lk_hit);
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_hit && !lk_miss && !ev_fill));
  p_replace_with_fill_r6: assert property (@(posedge clk) disable iff (!rst_n) ev_replace |-> ev_fill);
  p_fill_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n) ev_fill |-> fill_valid);
  p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(flush_start));
  p_walk_length_r9: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run == WALK);
  p_no_stray_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !inv_valid) |-> ev_inval_cnt == '0);
endmodule

bind tlb_split tlb_split_chk #(
  .S_WAYS(S_WAYS), .S_SETS(S_SETS), .L_WAYS(L_WAYS), .L_SETS(L_SETS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_large(lk_large), .fill_valid(fill_valid), .inv_valid(inv_valid),
  .flush_start(flush_start), .busy(busy), .ev_fill(ev_fill), .ev_replace(ev_replace),
  .ev_inval_cnt(ev_inval_cnt)
);

// File: tb/tlb_split_tb.sv
module tlb_split_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, fill_valid = 1'b0, fill_large = 1'b0;
  logic        inv_valid = 1'b0, flush_start = 1'b0;
  logic [31:0] lk_va = '0, fill_va = '0, fill_pa = '0, inv_va = '0;
  logic        lk_hit, lk_large, lk_miss, busy, ev_fill, ev_replace;
  logic [31:0] lk_pa;
  logic [3:0]  ev_inval_cnt;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tlb_split dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_pa(lk_pa), .lk_large(lk_large), .lk_miss(lk_miss), .fill_valid(fill_valid),
    .fill_va(fill_va), .fill_pa(fill_pa), .fill_large(fill_large), .inv_valid(inv_valid),
    .inv_va(inv_va), .flush_start(flush_start), .busy(busy), .ev_fill(ev_fill),
    .ev_replace(ev_replace), .ev_inval_cnt(ev_inval_cnt)
  );

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input bit hit, input logic [31:0] pa,
                      input bit lg, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    #1;
    chk(lk_hit == hit, {req, " hit"}, 32'(lk_hit), 32'(hit));
    chk(lk_miss == !hit, {req, " miss"}, 32'(lk_miss), 32'(!hit));
    if (hit) begin
      chk(lk_pa == pa, {req, " pa"}, lk_pa, pa);
      chk(lk_large == lg, {req, " large"}, 32'(lk_large), 32'(lg));
    end
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input bit lg,
                      input bit repl, input string req);
    @(negedge clk);
    fill_valid = 1'b1; fill_va = va; fill_pa = pa; fill_large = lg;
    #1;
    chk(ev_fill == 1'b1, {req, " ev_fill"}, 32'(ev_fill), 32'd1);
    chk(ev_replace == repl, {req, " ev_replace"}, 32'(ev_replace), 32'(repl));
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic inval(input logic [31:0] va, input int cnt, input string req);
    @(negedge clk);
    inv_valid = 1'b1; inv_va = va;
    #1;
    chk(ev_inval_cnt == cnt, {req, " inval count"}, 32'(ev_inval_cnt), 32'(cnt));
    @(posedge clk); #1;
    inv_valid = 1'b0;
  endtask

  task automatic flush(input int exp_sum, input logic [31:0] probe, input string req);
    int cyc = 0, sum = 0;
    @(negedge clk);
    flush_start = 1'b1;
    @(posedge clk); #1;
    flush_start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      fill_valid = 1'b0; lk_valid = 1'b0;
      #1;
      if (!busy) break;
      cyc++;
      sum += int'(ev_inval_cnt);
      if (cyc == 3) begin
        lk_valid = 1'b1; lk_va = probe;
        fill_valid = 1'b1; fill_va = probe; fill_pa = 32'hDEAD_0000; fill_large = 1'b0;
        #0.5;
        chk(!lk_hit && !lk_miss, "R10 lookup quiet during flush", 32'({lk_hit, lk_miss}), 32'd0);
        chk(!ev_fill, "R10 fill dropped during flush", 32'(ev_fill), 32'd0);
      end
    end
    chk(cyc == 16, {req, " busy cycles"}, 32'(cyc), 32'd16);
    if (exp_sum >= 0) chk(sum == exp_sum, {req, " invalidate total"}, 32'(sum), 32'(exp_sum));
  endtask

  task automatic t_reset;
    #1;
    chk(!busy, "R1 busy", 32'(busy), 32'd0);
    chk(!ev_fill && !ev_replace && ev_inval_cnt == 0, "R1 events", 32'({ev_fill, ev_replace, ev_inval_cnt}), 32'd0);
    look(32'h1234_5678, 1'b0, '0, 1'b0, "R1 empty small");
    look(32'h0840_0000, 1'b0, '0, 1'b0, "R1 empty large");
  endtask

  task automatic t_small;
    fill(32'h1234_5000, 32'hABCD_E000, 1'b0, 1'b0, "R2 fill");
    look(32'h1234_5678, 1'b1, 32'hABCD_E678, 1'b0, "R2");
    look(32'h1234_6678, 1'b0, '0, 1'b0, "R5 neighbour miss");
  endtask

  task automatic t_large;
    fill(32'h0840_0000, 32'h7FC0_0000, 1'b1, 1'b0, "R3 fill");
    look(32'h087F_FFFC, 1'b1, 32'h7FFF_FFFC, 1'b1, "R3");
    look(32'h0880_0000, 1'b0, '0, 1'b0, "R5 past large page");
  endtask

  task automatic t_overlap;
    fill(32'h0845_6000, 32'h1111_1000, 1'b0, 1'b0, "R4 fill small");
    look(32'h0845_6ABC, 1'b1, 32'h7FC5_6ABC, 1'b1, "R4 large wins");
  endtask

  task automatic t_sets;
    for (int i = 0; i < 16; i++)
      fill(32'h4000_0000 | (i << 12), 32'h2000_0000 | (i << 12), 1'b0, 1'b0, "R11 fill");
    for (int i = 0; i < 16; i++)
      look(32'h4000_0010 | (i << 12), 1'b1, 32'h2000_0010 | (i << 12), 1'b0, "R11 small set");
    fill(32'h0000_0000, 32'hC000_0000, 1'b1, 1'b0, "R11 large set0");
    fill(32'h0040_0000, 32'hC040_0000, 1'b1, 1'b0, "R11 large set1");
    look(32'h0012_3456, 1'b1, 32'hC012_3456, 1'b1, "R11 large set0");
    look(32'h0040_0010, 1'b1, 32'hC040_0010, 1'b1, "R11 large set1");
  endtask

  task automatic t_replace;
    for (int k = 0; k < 5; k++)
      fill(32'h7000_A000 | (k << 16), 32'h3000_0000 | (k << 12), 1'b0, k >= 3, "R6 fill");
    look(32'h4000_A000, 1'b0, '0, 1'b0, "R6 first evicted");
    look(32'h7000_A000, 1'b0, '0, 1'b0, "R6 second evicted");
    for (int k = 1; k < 5; k++)
      look(32'h7000_A000 | (k << 16), 1'b1, 32'h3000_0000 | (k << 12), 1'b0, "R6 resident");
  endtask

  task automatic t_refill;
    fill(32'h7002_A000, 32'h5555_5000, 1'b0, 1'b0, "R7 refill");
    look(32'h7002_A123, 1'b1, 32'h5555_5123, 1'b0, "R7 new frame");
    look(32'h7001_A000, 1'b1, 32'h3000_1000, 1'b0, "R7 neighbour kept");
    look(32'h7003_A000, 1'b1, 32'h3000_3000, 1'b0, "R7 neighbour kept");
    look(32'h7004_A000, 1'b1, 32'h3000_4000, 1'b0, "R7 neighbour kept");
  endtask

  task automatic t_inval;
    inval(32'h1234_5000, 1, "R8 single");
    look(32'h1234_5678, 1'b0, '0, 1'b0, "R8 gone");
    inval(32'h5555_5000, 0, "R8 absent");
    inval(32'h0845_6000, 2, "R8 both arrays");
    look(32'h0845_6ABC, 1'b0, '0, 1'b0, "R8 overlap gone");
    look(32'h0840_0000, 1'b0, '0, 1'b0, "R8 large gone");
    look(32'h4000_3000, 1'b1, 32'h2000_3000, 1'b0, "R8 other kept");
  endtask

  task automatic t_flush;
    flush(-1, 32'h9999_9000, "R9 first flush");
    look(32'h4000_3000, 1'b0, '0, 1'b0, "R9 small cleared");
    look(32'h0012_3456, 1'b0, '0, 1'b0, "R9 large cleared");
    fill(32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0, "R9 refill");
    fill(32'h0000_2000, 32'h0000_2000, 1'b0, 1'b0, "R9 refill");
    fill(32'h0000_3000, 32'h0000_3000, 1'b0, 1'b0, "R9 refill");
    fill(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, "R9 refill");
    fill(32'h0040_0000, 32'h0040_0000, 1'b1, 1'b0, "R9 refill");
    flush(5, 32'h9999_9000, "R9 second flush");
    look(32'h9999_9000, 1'b0, '0, 1'b0, "R10 probe fill dropped");
    look(32'h0000_1000, 1'b0, '0, 1'b0, "R9 after flush");
  endtask

  task automatic t_prio;
    @(negedge clk);
    inv_valid = 1'b1; inv_va = 32'h0000_1000;
    fill_valid = 1'b1; fill_va = 32'h0000_5000; fill_pa = 32'h0000_5000; fill_large = 1'b0;
    #1;
    chk(!ev_fill, "R12 fill loses to invalidate", 32'(ev_fill), 32'd0);
    @(posedge clk); #1;
    inv_valid = 1'b0; fill_valid = 1'b0;
    look(32'h0000_5000, 1'b0, '0, 1'b0, "R12 fill not stored");
    fill(32'h0000_6000, 32'h0000_6000, 1'b0, 1'b0, "R12 setup");
    @(negedge clk);
    flush_start = 1'b1; inv_valid = 1'b1; inv_va = 32'h0000_6000;
    #1;
    chk(ev_inval_cnt == 0, "R12 invalidate loses to flush", 32'(ev_inval_cnt), 32'd0);
    @(posedge clk); #1;
    flush_start = 1'b0; inv_valid = 1'b0;
    for (int i = 0; i < 40 && busy; i++) @(posedge clk);
    #1;
    look(32'h0000_6000, 1'b0, '0, 1'b0, "R12 flush ran");
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_small();
    t_large();
    t_overlap();
    t_sets();
    t_replace();
    t_refill();
    t_inval();
    t_flush();
    t_prio();
    repeat (2) @(posedge clk);
    report();
  end
endmodule